// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an operand addressing mode and its operand fields into the 16-bit data-memory address of that operand. It is placed between the instruction decoder and the data-memory port of a small 8-bit processor core. The decoder supplies a mode code, an immediate field and the values of the HL and DE pairs and the B and C registers. The block returns the address of the operand byte. For a 16-bit operand it also returns the address of the high byte.

The block has no clock and no state. Full 16-bit immediates pass straight through. An 8-bit offset is placed in one of two high pages: a folded window at the top of the map, or the peripheral register page. The block can add an unsigned displacement or index to HL. It can also locate a general register, given its 3-bit code, inside the selected bank of the register file, which is mapped into memory. When a pair operand in either page mode has an odd offset, the block raises a misalignment flag.

Top module: `oeag_top`

## Requirements
- R1: Mode code 0 (direct) gives `ea` equal to all 16 bits of `imm16`.
- R2: Mode code 1 (short page) uses the offset `o = imm16[7:0]`. It gives `ea = FE00H + o` when o is 20H to FFH, and `ea = FF00H + o` when o is 00H to 1FH. The result always lies in FE20H to FF1FH.
- R3: Mode code 2 (peripheral page) gives `ea = FF00H + imm16[7:0]`.
- R4: Mode code 3 gives `ea = de`. Mode code 4 gives `ea = hl`.
- R5: Mode code 5 (based) gives `ea = (hl + imm16[7:0]) mod 2^16`, with the offset zero-extended.
- R6: Mode code 6 gives `ea = (hl + b_reg) mod 2^16`. Mode code 7 gives `ea = (hl + c_reg) mod 2^16`. In both cases the register is zero-extended.
- R7: Mode code 8 (banked register) gives `ea = FEF8H - 8*bank_sel + reg_code`. The register codes are X=0, A=1, C=2, B=3, E=4, D=5, L=6, H=7. The result always lies in FEE0H to FEFFH.
- R8: In every mode, `ea_hi` equals `(ea + 1) mod 2^16`. This is the address of the high byte of a pair.
- R9: `misaligned` is 1 exactly when `is_pair` is 1, the mode is 1 or 2, and `imm16[0]` is 1. It is 0 in every other case.
- R10: Mode codes 9 to 15 are reserved. They give `ea = 0000H` and `misaligned = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_sel | input | 4 | Addressing mode code |
| is_pair | input | 1 | Operand is a 16-bit pair |
| imm16 | input | 16 | Immediate field; the low byte is the offset |
| hl | input | 16 | HL pair value |
| de | input | 16 | DE pair value |
| b_reg | input | 8 | B register value |
| c_reg | input | 8 | C register value |
| bank_sel | input | 2 | Selected register bank |
| reg_code | input | 3 | General register code |
| ea | output | 16 | Operand (low byte) address |
| ea_hi | output | 16 | High byte address for pair operands |
| misaligned | output | 1 | Odd pair offset in a page mode |

## Verification
The block holds no state, so a fault shows at the ports in the same evaluation as the stimulus that exposes it. A wrong fold boundary appears only at offsets 1FH and 20H. A lost carry or a sign-extended offset appears only when HL is near FFFFH or when the offset or index is 80H or above. Bank inversion errors appear as an address 8 or 24 bytes away from the expected one. For these reasons the random vectors are mixed with directed values at each of these edges.

// File: rtl/oeag_pkg.sv
package oeag_pkg;
  typedef enum logic [3:0] {
    AM_DIRECT  = 4'd0,
    AM_SHORT   = 4'd1,
    AM_SPECIAL = 4'd2,
    AM_IND_DE  = 4'd3,
    AM_IND_HL  = 4'd4,
    AM_BASED   = 4'd5,
    AM_IDX_B   = 4'd6,
    AM_IDX_C   = 4'd7,
    AM_GREG    = 4'd8
  } am_e;
endpackage

// File: rtl/oeag_page_map.sv
module oeag_page_map #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8,
  parameter logic [OFF_W-1:0] FOLD_LIM = 8'h20
) (
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] short_ea,
  output logic [ADDR_W-1:0] sfr_ea,
  output logic              odd
);
  localparam int TOP_W = ADDR_W - OFF_W;
  logic wrap;
  always_comb begin
    // Offsets below the limit fold onto the page above by setting bit OFF_W.
    wrap     = (off < FOLD_LIM);
    short_ea = {{(TOP_W-1){1'b1}}, wrap, off};
    sfr_ea   = {{TOP_W{1'b1}}, off};
    odd      = off[0];
  end
endmodule

// File: rtl/oeag_base_add.sv
module oeag_base_add #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  disp,
  output logic [ADDR_W-1:0] sum
);
  logic [ADDR_W-1:0] disp_ext;
  always_comb begin
    disp_ext = {{(ADDR_W-OFF_W){1'b0}}, disp};
    sum      = base + disp_ext;
  end
endmodule

// File: rtl/oeag_greg_map.sv
module oeag_greg_map #(
  parameter int ADDR_W  = 16,
  parameter int BANK_W  = 2,
  parameter int RCODE_W = 3,
  parameter logic [ADDR_W-1:0] GREG_TOP = 16'hFEF8
) (
  input  logic [BANK_W-1:0]  bank,
  input  logic [RCODE_W-1:0] code,
  output logic [ADDR_W-1:0]  addr
);
  localparam int PAD_W = ADDR_W - BANK_W - RCODE_W;
  logic [ADDR_W-1:0] bank_off;
  logic [ADDR_W-1:0] code_ext;
  always_comb begin
    bank_off = {{PAD_W{1'b0}}, bank, {RCODE_W{1'b0}}};
    code_ext = {{(ADDR_W-RCODE_W){1'b0}}, code};
    addr     = GREG_TOP - bank_off + code_ext;
  end
endmodule

// File: rtl/oeag_top.sv
module oeag_top #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 8,
  parameter int BANK_W  = 2,
  parameter int RCODE_W = 3
) (
  input  logic [3:0]         mode_sel,
  input  logic               is_pair,
  input  logic [ADDR_W-1:0]  imm16,
  input  logic [ADDR_W-1:0]  hl,
  input  logic [ADDR_W-1:0]  de,
  input  logic [OFF_W-1:0]   b_reg,
  input  logic [OFF_W-1:0]   c_reg,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic [RCODE_W-1:0] reg_code,
  output logic [ADDR_W-1:0]  ea,
  output logic [ADDR_W-1:0]  ea_hi,
  output logic               misaligned
);
  import oeag_pkg::*;

  localparam int N_ADD = 3;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [OFF_W-1:0]  offset;
  logic [ADDR_W-1:0] short_ea, sfr_ea, greg_ea;
  logic              off_odd;
  logic [OFF_W-1:0]  add_disp [N_ADD];
  logic [ADDR_W-1:0] add_sum  [N_ADD];
  am_e               mode;

  assign offset = imm16[OFF_W-1:0];
  assign mode   = am_e'(mode_sel);

  oeag_page_map #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_page (
    .off(offset), .short_ea(short_ea), .sfr_ea(sfr_ea), .odd(off_odd)
  );

  assign add_disp[0] = offset;
  assign add_disp[1] = b_reg;
  assign add_disp[2] = c_reg;

  for (genvar gi = 0; gi < N_ADD; gi++) begin : g_add
    oeag_base_add #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_add (
      .base(hl), .disp(add_disp[gi]), .sum(add_sum[gi])
    );
  end

  oeag_greg_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .RCODE_W(RCODE_W)) u_greg (
    .bank(bank_sel), .code(reg_code), .addr(greg_ea)
  );

  always_comb begin
    misaligned = 1'b0;
    unique case (mode)
      AM_DIRECT:  ea = imm16;
      AM_SHORT:   begin ea = short_ea; misaligned = is_pair & off_odd; end
      AM_SPECIAL: begin ea = sfr_ea;   misaligned = is_pair & off_odd; end
      AM_IND_DE:  ea = de;
      AM_IND_HL:  ea = hl;
      AM_BASED:   ea = add_sum[0];
      AM_IDX_B:   ea = add_sum[1];
      AM_IDX_C:   ea = add_sum[2];
      AM_GREG:    ea = greg_ea;
      default:    ea = '0;
    endcase
    ea_hi = ea + ONE;
  end
endmodule

// File: rtl/oeag_chk.sv
module oeag_chk #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 8,
  parameter int BANK_W  = 2,
  parameter int RCODE_W = 3
) (
  input logic [3:0]         mode_sel,
  input logic               is_pair,
  input logic [ADDR_W-1:0]  imm16,
  input logic [ADDR_W-1:0]  hl,
  input logic [ADDR_W-1:0]  de,
  input logic [BANK_W-1:0]  bank_sel,
  input logic [RCODE_W-1:0] reg_code,
  input logic [ADDR_W-1:0]  ea,
  input logic [ADDR_W-1:0]  ea_hi,
  input logic               misaligned
);
  always_comb begin
    if (!$isunknown({mode_sel, is_pair, imm16, hl, de, bank_sel, reg_code})) begin
      AST_PAIR_STEP: assert (ea_hi - ea == 16'd1); // R8
      if (mode_sel == 4'd0) AST_DIRECT_PASS: assert (ea == imm16); // R1
      if (mode_sel == 4'd1) AST_SHORT_WINDOW: assert (ea >= 16'hFE20 && ea <= 16'hFF1F && ea[7:0] == imm16[7:0]); // R2
      if (mode_sel == 4'd2) AST_SFR_PAGE: assert (ea[15:8] == 8'hFF && ea[7:0] == imm16[7:0]); // R3
      if (mode_sel == 4'd3) AST_IND_DE: assert (ea == de); // R4
      if (mode_sel == 4'd8) AST_GREG_RANGE: assert (ea[15:5] == 11'h7F7 && ea[2:0] == reg_code); // R7
      AST_ODD_FLAG: assert (!misaligned || (is_pair && ea[0] && (mode_sel == 4'd1 || mode_sel == 4'd2))); // R9
      if (mode_sel > 4'd8) AST_RESERVED_ZERO: assert (ea == 16'h0000 && !misaligned); // R10
    end
  end
endmodule

bind oeag_top oeag_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .RCODE_W(RCODE_W)) u_chk (
  .mode_sel(mode_sel), .is_pair(is_pair), .imm16(imm16), .hl(hl), .de(de),
  .bank_sel(bank_sel), .reg_code(reg_code), .ea(ea), .ea_hi(ea_hi), .misaligned(misaligned)
);

// File: tb/sim_oeag_top.sv
module sim_oeag_top;
  logic clk;
  logic rst_n;
  logic [3:0]  mode_sel;
  logic        is_pair;
  logic [15:0] imm16, hl, de;
  logic [7:0]  b_reg, c_reg;
  logic [1:0]  bank_sel;
  logic [2:0]  reg_code;
  logic [15:0] ea, ea_hi;
  logic        misaligned;
  int checks;
  int errors;
  bit done;

  oeag_top u0 (
    .mode_sel(mode_sel), .is_pair(is_pair), .imm16(imm16), .hl(hl), .de(de),
    .b_reg(b_reg), .c_reg(c_reg), .bank_sel(bank_sel), .reg_code(reg_code),
    .ea(ea), .ea_hi(ea_hi), .misaligned(misaligned)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] exp_ea(input logic [3:0] m);
    logic [15:0] o;
    o = {8'h00, imm16[7:0]};
    case (m)
      4'd0: return imm16;
      4'd1: return (o >= 16'h0020) ? 16'hFE00 + o : 16'hFF00 + o;
      4'd2: return 16'hFF00 + o;
      4'd3: return de;
      4'd4: return hl;
      4'd5: return hl + o;
      4'd6: return hl + {8'h00, b_reg};
      4'd7: return hl + {8'h00, c_reg};
      4'd8: return 16'hFEF8 - 16'(8 * int'(bank_sel)) + {13'd0, reg_code};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic exp_mis(input logic [3:0] m);
    return is_pair && (m == 4'd1 || m == 4'd2) && imm16[0];
  endfunction

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check_now();
    logic [15:0] e;
    e = exp_ea(mode_sel);
    checks++;
    if (ea !== e) begin
      errors++;
      $display("FAIL %s mode %0d ea actual %h expected %h", req_of(mode_sel), mode_sel, ea, e);
    end
    checks++;
    if (ea_hi !== e + 16'd1) begin
      errors++;
      $display("FAIL R8 ea_hi actual %h expected %h", ea_hi, e + 16'd1);
    end
    checks++;
    if (misaligned !== exp_mis(mode_sel)) begin
      errors++;
      $display("FAIL R9 misaligned actual %b expected %b", misaligned, exp_mis(mode_sel));
    end
  endtask

  task automatic apply(input logic [3:0] m, input logic p, input logic [15:0] im,
                       input logic [15:0] h, input logic [15:0] d, input logic [7:0] b,
                       input logic [7:0] c, input logic [1:0] bk, input logic [2:0] rc);
    @(posedge clk);
    mode_sel = m; is_pair = p; imm16 = im; hl = h; de = d;
    b_reg = b; c_reg = c; bank_sel = bk; reg_code = rc;
    @(negedge clk);
    check_now();
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    mode_sel = 4'd15; is_pair = 1'b1; imm16 = 16'hFFFF; hl = 16'h1234; de = 16'h5678;
    b_reg = 8'h11; c_reg = 8'h22; bank_sel = 2'd0; reg_code = 3'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_now(); // R10 idle state with a reserved code
    // R2 fold boundaries
    apply(4'd1, 1'b0, 16'h001F, 0, 0, 0, 0, 0, 0);
    apply(4'd1, 1'b0, 16'h0020, 0, 0, 0, 0, 0, 0);
    apply(4'd1, 1'b0, 16'h0000, 0, 0, 0, 0, 0, 0);
    apply(4'd1, 1'b0, 16'hABFF, 0, 0, 0, 0, 0, 0);
    // R9 odd pair in both page modes, and outside them
    apply(4'd1, 1'b1, 16'h0021, 0, 0, 0, 0, 0, 0);
    apply(4'd2, 1'b1, 16'h0033, 0, 0, 0, 0, 0, 0);
    apply(4'd2, 1'b1, 16'h0034, 0, 0, 0, 0, 0, 0);
    apply(4'd0, 1'b1, 16'h0035, 0, 0, 0, 0, 0, 0);
    // R3 page top, R8 wrap of ea_hi
    apply(4'd2, 1'b0, 16'h00FF, 0, 0, 0, 0, 0, 0);
    apply(4'd0, 1'b0, 16'hFFFF, 0, 0, 0, 0, 0, 0);
    // R5, R6 carry discarded and no sign extension
    apply(4'd5, 1'b0, 16'h0080, 16'hFFF0, 0, 0, 0, 0, 0);
    apply(4'd6, 1'b0, 0, 16'hFFFF, 0, 8'hFF, 8'h01, 0, 0);
    apply(4'd7, 1'b0, 0, 16'h0010, 0, 8'h01, 8'h90, 0, 0);
    // R4 pair indirect
    apply(4'd3, 1'b1, 16'h0001, 16'h1111, 16'hBEEF, 0, 0, 0, 0);
    apply(4'd4, 1'b1, 16'h0001, 16'hCAFE, 16'hBEEF, 0, 0, 0, 0);
    // R7 all banks, all codes
    for (int bk = 0; bk < 4; bk++)
      for (int rc = 0; rc < 8; rc++)
        apply(4'd8, 1'b0, 0, 0, 0, 0, 0, 2'(bk), 3'(rc));
    // R10 every reserved code with an odd pair offset
    for (int m = 9; m < 16; m++)
      apply(4'(m), 1'b1, 16'h00FF, 16'hFFFF, 16'hFFFF, 8'hFF, 8'hFF, 2'd3, 3'd7);
    // random mix covering R1 to R10
    for (int i = 0; i < 3000; i++)
      apply(4'($urandom_range(0, 15)), 1'($urandom), 16'($urandom), 16'($urandom),
            16'($urandom), 8'($urandom), 8'($urandom), 2'($urandom), 3'($urandom));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule